// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of an I/O bus. It gives software access to device configuration space through two small port ranges. A 32-bit address register holds a configuration target: an enable flag, a bus number, a device/function number and a register number of up to 12 bits. A four-byte data window turns each host access into one configuration request on a target interface. Byte, halfword and dword accesses to the window are placed on the right byte lanes. The request waits for the target's completion before the host access finishes.

The host presents one access at a time with `io_valid` and waits for the one-cycle `io_done` pulse. Data on the host side is right-aligned: the least significant byte of the access is always in `io_wdata[7:0]` and `io_rdata[7:0]`.

The controller is a three-state machine:
- **IDLE** waits for `io_valid`.
  - *IDLE→TARGET* is taken for a data-window access while the enable bit is set.
  - *IDLE→REPLY* is taken for every other access.
- **TARGET** drives `cfg_req`.
  - *TARGET→REPLY* is taken in the cycle `cfg_done` is high.
- **REPLY** pulses `io_done`.
  - *REPLY→IDLE* follows unconditionally.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register reads 0x00000000, and `cfg_req` and `io_done` are low.
- R2: A dword access (`io_size` 2 or 3) that writes any port 0xCF8–0xCFB loads the address register. Bit 31 (enable) and bits 27:2 are stored. Bits 30:28 and 1:0 read as zero, so a write of 0x80000000 reads back as 0x80000000 and a write of 0xFFFFFFFF reads back as 0x8FFFFFFC.
- R3: Byte writes (`io_size` 0) and halfword writes (`io_size` 1) to 0xCF8–0xCFB leave the address register unchanged. A byte read of the register returns the byte at lane port[1:0]. A halfword read returns the lanes starting at {port[1],0}. Either result is right-aligned and zero-extended.
- R4: While bit 31 of the address register is 0, reads of 0xCFC–0xCFF return 0xFFFFFFFF and writes there are dropped. No request is made to the target in either case.
- R5: With bit 31 set, a window access raises exactly one request with these fields:
  - `cfg_bus` = address bits 23:16
  - `cfg_devfn` = bits 15:8
  - `cfg_reg` = {bits 27:24, bits 7:2}, a 10-bit dword index
- R6: The lane offset is port[1:0] for a byte access, {port[1],0} for a halfword access and 0 for a dword access. `cfg_be` is 0001, 0011 or 1111 shifted left by that offset. `cfg_wdata` is the right-aligned write data shifted left by 8×offset.
- R7: A window read returns `cfg_rdata` shifted right by 8×offset and masked to the access size.
- R8: `cfg_req` and all request fields stay stable until `cfg_done`. `io_done` is a single-cycle pulse one cycle after the `cfg_done` cycle. An access that makes no request completes with `io_done` one cycle after acceptance.
- R9: Accesses to any port outside 0xCF8–0xCFF read 0xFFFFFFFF, do not change the address register and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Host access strobe, sampled in IDLE |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port number |
| io_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| io_wdata | input | 32 | Right-aligned write data |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Right-aligned read data, valid with io_done |
| cfg_req | output | 1 | Configuration request, held until cfg_done |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 10 | Dword register index (extended) |
| cfg_be | output | 4 | Byte lane enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_done | input | 1 | Target completion |
| cfg_rdata | input | 32 | Target read data, valid with cfg_done |

## Verification
The bench targets several corner cases, each with a distinct wrong outcome:

- **Reserved address bits.** The all-ones write exposes a design that stores bits 30:28 or 1:0; the readback would not be 0x8FFFFFFC.
- **Narrow writes to the address register.** A bridge that merges byte or halfword writes into the register would move the target.
- **Sub-dword window accesses.** Upper-lane byte and halfword accesses, including a halfword at an odd port, catch a bridge that ignores the offset or fails to mask port bit 0. Such a bridge would send the wrong `cfg_be` and corrupt neighbouring bytes in the target.
- **Extended register bits.** Two addresses that differ only in bits 27:24 must reach different target registers.
- **Disabled window and foreign ports.** These must stay silent toward the target and read all ones.
- **Target latency.** Latencies of several cycles check that the request is held and that completion is timed from `cfg_done`.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TARGET = 2'd1,
        ST_REPLY  = 2'd2
    } fsm_state_e;

    // access size code on io_size: 0 byte, 1 halfword, 2/3 dword
    function automatic logic [1:0] lane_off(input logic [1:0] size, input logic [1:0] lo);
        case (size)
            2'd0:    lane_off = lo;
            2'd1:    lane_off = {lo[1], 1'b0};
            default: lane_off = 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] lane_count(input logic [1:0] size);
        case (size)
            2'd0:    lane_count = 3'd1;
            2'd1:    lane_count = 3'd2;
            default: lane_count = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] WMASK  = 32'h8FFF_FFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr_en)
            value <= wdata & WMASK;
    end

endmodule

// File: rtl/cfgp_lane_place.sv
module cfgp_lane_place
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]          size,
    input  logic [1:0]          lo,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   dout
);

    localparam int LANES = DATA_W / 8;

    logic [1:0]        off;
    logic [2:0]        nb;
    logic [LANES-1:0]  msk;
    logic [DATA_W-1:0] dmask;

    assign off = lane_off(size, lo);
    assign nb  = lane_count(size);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign msk[i]         = (nb > 3'(i));
            assign dmask[8*i +: 8] = {8{msk[i]}};
        end
    endgenerate

    assign be   = msk << off;
    assign dout = (din & dmask) << {off, 3'b000};

endmodule

// File: rtl/cfgp_lane_extract.sv
module cfgp_lane_extract
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [1:0]        lo,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int LANES = DATA_W / 8;

    logic [1:0]        off;
    logic [2:0]        nb;
    logic [DATA_W-1:0] dmask;

    assign off = lane_off(size, lo);
    assign nb  = lane_count(size);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign dmask[8*i +: 8] = {8{(nb > 3'(i))}};
        end
    endgenerate

    assign dout = (din >> {off, 3'b000}) & dmask;

endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_valid,
    input  logic       to_target,
    input  logic       cfg_done,
    output fsm_state_e state,
    output logic       accept,
    output logic       launch,
    output logic       cfg_req,
    output logic       capture_rsp,
    output logic       io_done
);

    fsm_state_e state_q, state_d;

    assign state = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (io_valid) state_d = to_target ? ST_TARGET : ST_REPLY;
            ST_TARGET: if (cfg_done) state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        accept      = 1'b0;
        launch      = 1'b0;
        cfg_req     = 1'b0;
        capture_rsp = 1'b0;
        io_done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = io_valid;
                launch = io_valid & to_target;
            end
            ST_TARGET: begin
                cfg_req     = 1'b1;
                capture_rsp = cfg_done;
            end
            ST_REPLY: io_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgp_pkg::*;
#(
    parameter int                PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC,
    parameter int                DATA_W    = 32,
    parameter int                BUS_W     = 8,
    parameter int                DEVFN_W   = 8,
    parameter int                EXT_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_valid,
    input  logic                          io_write,
    input  logic [PORT_W-1:0]             io_addr,
    input  logic [1:0]                    io_size,
    input  logic [DATA_W-1:0]             io_wdata,
    output logic                          io_done,
    output logic [DATA_W-1:0]             io_rdata,
    output logic                          cfg_req,
    output logic                          cfg_write,
    output logic [BUS_W-1:0]              cfg_bus,
    output logic [DEVFN_W-1:0]            cfg_devfn,
    output logic [EXT_W+6-1:0]            cfg_reg,
    output logic [DATA_W/8-1:0]           cfg_be,
    output logic [DATA_W-1:0]             cfg_wdata,
    input  logic                          cfg_done,
    input  logic [DATA_W-1:0]             cfg_rdata
);

    localparam int LANES      = DATA_W / 8;
    localparam int IDX_W      = 6;
    localparam int REG_W      = EXT_W + IDX_W;
    localparam int IDX_LSB    = 2;
    localparam int DEVFN_LSB  = 8;
    localparam int BUS_LSB    = DEVFN_LSB + DEVFN_W;
    localparam int EXT_LSB    = BUS_LSB + BUS_W;
    localparam int ENABLE_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] WMASK =
        (DATA_W'(1) << ENABLE_BIT) | ((DATA_W'(1) << (EXT_LSB + EXT_W)) - DATA_W'(4));

    // address register and decode
    logic [DATA_W-1:0] addr_q;
    logic              hit_addr, hit_win, to_target, addr_wr;

    assign hit_addr  = (io_addr[PORT_W-1:2] == ADDR_PORT[PORT_W-1:2]);
    assign hit_win   = (io_addr[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
    assign to_target = hit_win & addr_q[ENABLE_BIT];

    // controller
    fsm_state_e fsm_st;
    logic       accept, launch, capture_rsp;

    cfgp_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_valid   (io_valid),
        .to_target  (to_target),
        .cfg_done   (cfg_done),
        .state      (fsm_st),
        .accept     (accept),
        .launch     (launch),
        .cfg_req    (cfg_req),
        .capture_rsp(capture_rsp),
        .io_done    (io_done)
    );

    assign addr_wr = accept & io_write & hit_addr & io_size[1];

    cfgp_addr_reg #(.DATA_W(DATA_W), .WMASK(WMASK)) areg_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(addr_wr),
        .wdata(io_wdata),
        .value(addr_q)
    );

    // lane steering: outbound placement, local readback, target readback
    logic [LANES-1:0]  be_now;
    logic [DATA_W-1:0] wdata_now, local_rd, tgt_rd;
    logic [1:0]        q_size, q_lo;
    logic              q_write;

    cfgp_lane_place #(.DATA_W(DATA_W)) place_i (
        .size(io_size),
        .lo  (io_addr[1:0]),
        .din (io_wdata),
        .be  (be_now),
        .dout(wdata_now)
    );

    cfgp_lane_extract #(.DATA_W(DATA_W)) local_ext_i (
        .size(io_size),
        .lo  (io_addr[1:0]),
        .din (addr_q),
        .dout(local_rd)
    );

    cfgp_lane_extract #(.DATA_W(DATA_W)) tgt_ext_i (
        .size(q_size),
        .lo  (q_lo),
        .din (cfg_rdata),
        .dout(tgt_rd)
    );

    // captured request and reply data
    logic [BUS_W-1:0]   q_bus;
    logic [DEVFN_W-1:0] q_devfn;
    logic [REG_W-1:0]   q_reg;
    logic [LANES-1:0]   q_be;
    logic [DATA_W-1:0]  q_wdata, rsp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bus   <= '0;
            q_devfn <= '0;
            q_reg   <= '0;
            q_be    <= '0;
            q_wdata <= '0;
            q_write <= 1'b0;
            q_size  <= '0;
            q_lo    <= '0;
            rsp_q   <= '0;
        end else begin
            if (launch) begin
                q_bus   <= addr_q[BUS_LSB +: BUS_W];
                q_devfn <= addr_q[DEVFN_LSB +: DEVFN_W];
                q_reg   <= {addr_q[EXT_LSB +: EXT_W], addr_q[IDX_LSB +: IDX_W]};
                q_be    <= be_now;
                q_wdata <= wdata_now;
                q_write <= io_write;
                q_size  <= io_size;
                q_lo    <= io_addr[1:0];
            end
            if (accept && !to_target)
                rsp_q <= io_write ? '0 : (hit_addr ? local_rd : '1);
            if (capture_rsp)
                rsp_q <= q_write ? '0 : tgt_rd;
        end
    end

    assign io_rdata  = rsp_q;
    assign cfg_write = q_write;
    assign cfg_bus   = q_bus;
    assign cfg_devfn = q_devfn;
    assign cfg_reg   = q_reg;
    assign cfg_be    = q_be;
    assign cfg_wdata = q_wdata;

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        io_valid,
    input logic        io_write,
    input logic [1:0]  io_size,
    input logic        io_done,
    input logic        hit_addr,
    input logic        hit_win,
    input logic [31:0] addr_q,
    input fsm_state_e  st,
    input logic        cfg_req,
    input logic        cfg_write,
    input logic [7:0]  cfg_bus,
    input logic [7:0]  cfg_devfn,
    input logic [9:0]  cfg_reg,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic        cfg_done
);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_done) |=> (cfg_req && $stable({cfg_write, cfg_bus, cfg_devfn, cfg_reg, cfg_be, cfg_wdata})));

    assert_reply_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_done) |=> (io_done && !cfg_req));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);

    assert_local_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_valid && !(hit_win && addr_q[31])) |=> (io_done && !cfg_req));

    assert_be_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}));

    assert_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_bus == addr_q[23:16] && cfg_devfn == addr_q[15:8]
                     && cfg_reg == {addr_q[27:24], addr_q[7:2]}));

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_valid && !addr_q[31]) |=> !cfg_req);

    assert_narrow_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_valid && io_write && hit_addr && !io_size[1]) |=> $stable(addr_q));

    assert_foreign_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && io_valid && !hit_addr && !hit_win) |=> (!cfg_req && $stable(addr_q)));

endmodule

bind cfg_port_bridge cfgp_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_valid (io_valid),
    .io_write (io_write),
    .io_size  (io_size),
    .io_done  (io_done),
    .hit_addr (hit_addr),
    .hit_win  (hit_win),
    .addr_q   (addr_q),
    .st       (fsm_st),
    .cfg_req  (cfg_req),
    .cfg_write(cfg_write),
    .cfg_bus  (cfg_bus),
    .cfg_devfn(cfg_devfn),
    .cfg_reg  (cfg_reg),
    .cfg_be   (cfg_be),
    .cfg_wdata(cfg_wdata),
    .cfg_done (cfg_done)
);

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_valid, io_write;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic        io_done;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_write;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [9:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_done;
    logic [31:0] cfg_rdata;

    always #2.5 clk = ~clk;

    cfg_port_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_done(cfg_done), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] tgt_default(input logic [25:0] key);
        return {6'h2A, key};
    endfunction

    // ---------------- target: simple register array ----------------
    logic [31:0] tgt_mem [logic [25:0]];
    int          tgt_lat = 0;
    int          tgt_reqs = 0;
    logic [3:0]  lt_be;
    logic [31:0] lt_wdata;
    logic [7:0]  lt_bus, lt_devfn;
    logic [9:0]  lt_reg;

    initial begin
        cfg_done  = 1'b0;
        cfg_rdata = '0;
        forever begin
            @(negedge clk);
            if (cfg_req) begin
                repeat (tgt_lat) @(negedge clk);
                begin
                    logic [25:0] key;
                    logic [31:0] cur;
                    key = {cfg_bus, cfg_devfn, cfg_reg};
                    cur = tgt_mem.exists(key) ? tgt_mem[key] : tgt_default(key);
                    tgt_reqs++;
                    lt_be = cfg_be; lt_wdata = cfg_wdata;
                    lt_bus = cfg_bus; lt_devfn = cfg_devfn; lt_reg = cfg_reg;
                    if (cfg_write) begin
                        for (int b = 0; b < 4; b++)
                            if (cfg_be[b]) cur[8*b +: 8] = cfg_wdata[8*b +: 8];
                        tgt_mem[key] = cur;
                        cfg_rdata = '0;
                    end else begin
                        cfg_rdata = cur;
                    end
                end
                cfg_done = 1'b1;
                @(negedge clk);
                cfg_done = 1'b0;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    logic [31:0] exp_addr = '0;
    logic [31:0] exp_mem [logic [25:0]];
    bit          exp_busy = 1'b0;
    bit          exp_target = 1'b0;

    // per-clock comparison: no request or completion outside the modelled windows
    always @(posedge clk) begin
        if (rst_n === 1'b1)
            check(!((cfg_req && !exp_target) || (io_done && !exp_busy)), "R4/R9",
                  "stray request or completion", {30'd0, cfg_req, io_done},
                  {30'd0, exp_target, exp_busy});
    end

    function automatic logic [31:0] model_op(input bit wr, input logic [15:0] port,
                                             input logic [1:0] sz, input logic [31:0] wd);
        int off, nb;
        logic [31:0] mask, cur;
        logic [25:0] key;
        off  = (sz == 2'd0) ? int'(port[1:0]) : (sz == 2'd1) ? (port[1] ? 2 : 0) : 0;
        nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 32'd1);
        if (port[15:2] == 14'h033E) begin
            if (wr) begin
                if (sz[1]) exp_addr = wd & 32'h8FFF_FFFC;
                return 32'd0;
            end
            return (exp_addr >> (8*off)) & mask;
        end
        if (port[15:2] == 14'h033F && exp_addr[31]) begin
            key = {exp_addr[23:16], exp_addr[15:8], exp_addr[27:24], exp_addr[7:2]};
            cur = exp_mem.exists(key) ? exp_mem[key] : tgt_default(key);
            if (wr) begin
                for (int b = 0; b < 4; b++)
                    if (b >= off && b < off + nb) cur[8*b +: 8] = wd[8*(b-off) +: 8];
                exp_mem[key] = cur;
                return 32'd0;
            end
            return (cur >> (8*off)) & mask;
        end
        return wr ? 32'd0 : 32'hFFFF_FFFF;
    endfunction

    task automatic io_op(input bit wr, input logic [15:0] port, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output logic [31:0] exp_rd, output int lat);
        exp_target = (port[15:2] == 14'h033F) && exp_addr[31];
        exp_busy   = 1'b1;
        exp_rd     = model_op(wr, port, sz, wd);
        io_valid = 1'b1; io_write = wr; io_addr = port; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_valid = 1'b0;
        lat = 1;
        while (!io_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(io_done === 1'b1, "R8", "access never completed", {31'd0, io_done}, 32'd1);
        rd = io_rdata;
        @(negedge clk);
        exp_busy = 1'b0;
        exp_target = 1'b0;
    endtask

    task automatic op(input bit wr, input logic [15:0] port, input logic [1:0] sz,
                      input logic [31:0] wd, input string req, input int exp_lat);
        logic [31:0] rd, er;
        int lat;
        io_op(wr, port, sz, wd, rd, er, lat);
        if (!wr) check(rd === er, req, "read data", rd, er);
        if (exp_lat > 0) check(lat == exp_lat, "R8", "completion latency", lat, exp_lat);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #750000;
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog expired: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int r0;
        rst_n = 1'b0; io_valid = 1'b0; io_write = 1'b0;
        io_addr = '0; io_size = '0; io_wdata = '0;
        repeat (3) @(negedge clk);
        check(io_done === 1'b0 && cfg_req === 1'b0, "R1", "outputs idle in reset",
              {30'd0, io_done, cfg_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value of the address register
        op(0, 16'h0CF8, 2'd2, 0, "R1", 1);

        // R2: presence pattern and reserved bits
        op(1, 16'h0CF8, 2'd2, 32'h8000_0000, "R2", 1);
        op(0, 16'h0CF8, 2'd2, 0, "R2", 1);
        op(1, 16'h0CF8, 2'd2, 32'hFFFF_FFFF, "R2", 1);
        op(0, 16'h0CF8, 2'd2, 0, "R2", 1);

        // R3: narrow writes ignored, narrow reads steered
        op(1, 16'h0CFB, 2'd0, 32'h0000_0000, "R3", 1);
        op(1, 16'h0CF8, 2'd1, 32'h0000_1234, "R3", 1);
        op(0, 16'h0CF8, 2'd2, 0, "R3", 1);
        op(0, 16'h0CFB, 2'd0, 0, "R3", 1);
        op(0, 16'h0CF8, 2'd1, 0, "R3", 1);
        op(0, 16'h0CFB, 2'd1, 0, "R3", 1);

        // R4: enable clear -> all ones, no request
        op(1, 16'h0CF8, 2'd2, 32'h0012_3444, "R4", 1);
        r0 = tgt_reqs;
        op(0, 16'h0CFC, 2'd2, 0, "R4", 1);
        op(1, 16'h0CFD, 2'd0, 32'h77, "R4", 1);
        check(tgt_reqs == r0, "R4", "target requests while disabled", tgt_reqs, r0);

        // R5/R6: enabled dword write, fields and lanes
        op(1, 16'h0CF8, 2'd2, 32'h8A12_3444, "R5", 1);
        tgt_lat = 0;
        op(1, 16'h0CFC, 2'd2, 32'hDEAD_BEEF, "R5", 2);
        check(tgt_reqs == r0 + 1, "R5", "one request per access", tgt_reqs, r0 + 1);
        check({lt_bus, lt_devfn} == 16'h1234, "R5", "bus/devfn", {lt_bus, lt_devfn}, 32'h1234);
        check(lt_reg == 10'h291, "R5", "extended register index", lt_reg, 32'h291);
        check(lt_be == 4'hF, "R6", "dword byte enables", lt_be, 32'hF);
        op(0, 16'h0CFC, 2'd2, 0, "R7", 2);

        // R6/R7: byte lane 2
        tgt_lat = 3;
        op(1, 16'h0CFE, 2'd0, 32'h0000_005A, "R6", 5);
        check(lt_be == 4'b0100, "R6", "byte enables port+2", lt_be, 32'h4);
        check(lt_wdata[23:16] == 8'h5A, "R6", "byte placed in lane 2", lt_wdata, 32'h005A_0000);
        op(0, 16'h0CFE, 2'd0, 0, "R7", 5);
        tgt_lat = 1;
        op(0, 16'h0CFC, 2'd2, 0, "R7", 3);

        // R6/R7: halfword at odd port uses upper half
        op(1, 16'h0CFF, 2'd1, 32'h0000_1234, "R6", 3);
        check(lt_be == 4'b1100, "R6", "halfword enables upper", lt_be, 32'hC);
        check(lt_wdata[31:16] == 16'h1234, "R6", "halfword lanes", lt_wdata, 32'h1234_0000);
        op(0, 16'h0CFE, 2'd1, 0, "R7", 3);
        op(0, 16'h0CFD, 2'd0, 0, "R7", 3);
        op(0, 16'h0CFC, 2'd1, 0, "R7", 3);

        // R5: extended bits select a different register
        op(1, 16'h0CF8, 2'd2, 32'h8012_3444, "R5", 1);
        op(0, 16'h0CFC, 2'd2, 0, "R5", 3);
        check(lt_reg == 10'h011, "R5", "register index without ext bits", lt_reg, 32'h011);

        // R9: foreign ports
        r0 = tgt_reqs;
        op(0, 16'h0080, 2'd2, 0, "R9", 1);
        op(1, 16'h0CF4, 2'd2, 32'h0000_0000, "R9", 1);
        op(1, 16'h0D00, 2'd2, 32'h0000_0000, "R9", 1);
        op(0, 16'h0CF8, 2'd2, 0, "R9", 1);
        check(tgt_reqs == r0, "R9", "no request on foreign ports", tgt_reqs, r0);

        // R4: disable again
        op(1, 16'h0CF8, 2'd2, 32'h0012_3444, "R4", 1);
        op(0, 16'h0CFE, 2'd0, 0, "R4", 1);
        check(tgt_reqs == r0, "R4", "no request after disable", tgt_reqs, r0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule